// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This block turns the two end addresses of a pixel span into the byte-lane enable mask that a partial store uses at the span's edges. It takes a start address and an end address, an element size of 8, 16 or 32 bits, and a lane-order select. It returns one bit per element of an 8-byte block, so the mask is 8, 4 or 2 bits wide. The result is placed in the low bits of a 64-bit word, and all other bits of that word are zero.

The left mask enables the elements of the block at and after the start address. The right mask enables the elements up to and including the end address. When both addresses lie in the same 8-byte block, the result is the intersection of the two masks. Otherwise it is the left mask alone. A 32-bit addressing mode compares only the low 32 address bits when it decides whether both addresses share a block.

When flag update is requested, the block also produces the negative, zero, overflow and carry codes of start minus end, at both 32-bit and 64-bit width. It raises a write strobe for these codes. All results are registered and appear one cycle after the request.

Top module: `edge_mask_gen`

## Requirements
- R1: `out_valid` rises in the cycle after a cycle with `in_valid` high and is low otherwise; outputs change only on such requests.
- R2: elem_size 0, lane order big-endian (`little_end`=0): with k = addr_a[2:0], left = 0xFF>>k; with n = addr_b[2:0], right = (0xFF<<(7-n)) truncated to 8 bits.
- R3: elem_size 0, little-endian: left = (0xFF<<k) truncated to 8 bits; right = 0xFF>>(7-n).
- R4: elem_size 1 (16-bit), index = address bits [2:1], 4-bit masks: big-endian left {F,7,3,1}, right {8,C,E,F}; little-endian left {F,E,C,8}, right {1,3,7,F}, listed by index 0..3.
- R5: elem_size 2 (32-bit), index = address bit 2, 2-bit masks: big-endian left {3,1}, right {2,3}; little-endian left {3,2}, right {1,3}.
- R6: if addr_a and addr_b are equal with bits [2:0] ignored, mask_out = left AND right; otherwise mask_out = left. mask_out is zero-extended to 64 bits.
- R7: with `narrow_mode`=1, only address bits [31:3] take part in the same-block comparison.
- R8: cc_wide = {N,Z,V,C} (bit 3 down to bit 0) of the 64-bit subtraction addr_a − addr_b, where C is the unsigned borrow; the full untruncated addresses are used even in narrow mode.
- R9: cc_narrow = {N,Z,V,C} of the subtraction addr_a[31:0] − addr_b[31:0].
- R10: `flag_we` is high for one cycle exactly when a request had `flags_en`=1; a request with `flags_en`=0 leaves cc_narrow and cc_wide unchanged.
- R11: during reset all outputs are zero.
- R12: elem_size 3 behaves exactly like elem_size 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| addr_a | input | 64 | Span start address |
| addr_b | input | 64 | Span end address |
| elem_size | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: as 0 |
| little_end | input | 1 | Lane order: 1 selects little-endian |
| narrow_mode | input | 1 | Compare blocks on 32-bit addresses |
| flags_en | input | 1 | Update condition codes |
| out_valid | output | 1 | Result valid |
| mask_out | output | 64 | Zero-extended edge mask |
| flag_we | output | 1 | Condition-code write strobe |
| cc_narrow | output | 4 | {N,Z,V,C} of the 32-bit subtraction |
| cc_wide | output | 4 | {N,Z,V,C} of the 64-bit subtraction |

## Verification
The mask decision and the flag update both complete in the cycle of a single request. This matters most in narrow mode, because the block comparison there uses truncated addresses while the flags use the full ones. The bench sends requests whose upper address halves differ but whose low halves share a block, with flags enabled. It then checks that the mask is the intersection of the two edges and that the 64-bit codes still reflect the nonzero upper difference. Requests with flags disabled are interleaved with these, and the scoreboard expects the codes from the last flag-setting request to persist.

// File: rtl/edge_mask_gen.sv
module edge_mask_gen #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [1:0]        elem_size,
  input  logic              little_end,
  input  logic              narrow_mode,
  input  logic              flags_en,
  output logic              out_valid,
  output logic [ADDR_W-1:0] mask_out,
  output logic              flag_we,
  output logic [3:0]        cc_narrow,
  output logic [3:0]        cc_wide
);
  localparam int LANES   = 8;
  localparam int IDX_W   = $clog2(LANES);

  logic [IDX_W-1:0] ka, kb, top;
  logic [LANES-1:0] ones, left_m, right_m, edge_m;
  logic             same_blk;
  logic [ADDR_W:0]  dw;
  logic [NARROW_W:0] dn;
  logic [3:0]       ccw_n, ccn_n;

  always_comb begin
    case (elem_size)
      2'd1: begin
        ka   = {1'b0, addr_a[2:1]};
        kb   = {1'b0, addr_b[2:1]};
        ones = 8'h0F;
        top  = 3'd3;
      end
      2'd2: begin
        ka   = {2'b0, addr_a[2]};
        kb   = {2'b0, addr_b[2]};
        ones = 8'h03;
        top  = 3'd1;
      end
      default: begin
        ka   = addr_a[2:0];
        kb   = addr_b[2:0];
        ones = 8'hFF;
        top  = 3'd7;
      end
    endcase
  end

  always_comb begin
    if (little_end) begin
      left_m  = (ones << ka) & ones;
      right_m = ones >> (top - kb);
    end else begin
      left_m  = ones >> ka;
      right_m = (ones << (top - kb)) & ones;
    end
  end

  assign same_blk = narrow_mode ? (addr_a[NARROW_W-1:IDX_W] == addr_b[NARROW_W-1:IDX_W])
                                : (addr_a[ADDR_W-1:IDX_W] == addr_b[ADDR_W-1:IDX_W]);
  assign edge_m   = same_blk ? (left_m & right_m) : left_m;

  assign dw = {1'b0, addr_a} - {1'b0, addr_b};
  assign dn = {1'b0, addr_a[NARROW_W-1:0]} - {1'b0, addr_b[NARROW_W-1:0]};

  assign ccw_n = {dw[ADDR_W-1], dw[ADDR_W-1:0] == '0,
                  (addr_a[ADDR_W-1] ^ addr_b[ADDR_W-1]) & (dw[ADDR_W-1] ^ addr_a[ADDR_W-1]),
                  dw[ADDR_W]};
  assign ccn_n = {dn[NARROW_W-1], dn[NARROW_W-1:0] == '0,
                  (addr_a[NARROW_W-1] ^ addr_b[NARROW_W-1]) & (dn[NARROW_W-1] ^ addr_a[NARROW_W-1]),
                  dn[NARROW_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flag_we   <= 1'b0;
      mask_out  <= '0;
      cc_narrow <= '0;
      cc_wide   <= '0;
    end else begin
      out_valid <= in_valid;
      flag_we   <= in_valid & flags_en;
      if (in_valid) mask_out <= {{(ADDR_W-LANES){1'b0}}, edge_m};
      if (in_valid && flags_en) begin
        cc_narrow <= ccn_n;
        cc_wide   <= ccw_n;
      end
    end
  end
endmodule

// File: rtl/edge_mask_gen_chk.sv
module edge_mask_gen_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        elem_size,
  input logic              flags_en,
  input logic              out_valid,
  input logic [ADDR_W-1:0] mask_out,
  input logic              flag_we,
  input logic [3:0]        cc_narrow,
  input logic [3:0]        cc_wide
);
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(mask_out)); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mask_out[ADDR_W-1:8] == '0); // R6
  AST_HALF_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_size == 2'd1) |=> mask_out[7:4] == 4'h0); // R4
  AST_WORD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_size == 2'd2) |=> mask_out[7:2] == 6'h0); // R5
  AST_WE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flags_en) |=> flag_we); // R10
  AST_WE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && flags_en) |=> !flag_we); // R10
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |-> ($stable(cc_narrow) && $stable(cc_wide))); // R10
  AST_ZERO_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && cc_wide[2]) |-> cc_narrow[2]); // R8
endmodule

bind edge_mask_gen edge_mask_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_size(elem_size),
  .flags_en(flags_en), .out_valid(out_valid), .mask_out(mask_out),
  .flag_we(flag_we), .cc_narrow(cc_narrow), .cc_wide(cc_wide)
);

// File: tb/edge_mask_gen_bench.sv
module edge_mask_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] addr_a = '0, addr_b = '0;
  logic [1:0] elem_size = '0;
  logic little_end = 1'b0, narrow_mode = 1'b0, flags_en = 1'b0;
  logic out_valid, flag_we;
  logic [63:0] mask_out;
  logic [3:0] cc_narrow, cc_wide;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [63:0] mask;
    logic        we;
    logic [3:0]  cn;
    logic [3:0]  cw;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [3:0] cn_m = '0, cw_m = '0;

  always #10 clk = ~clk;

  edge_mask_gen u_edge_mask_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr_a(addr_a), .addr_b(addr_b),
    .elem_size(elem_size), .little_end(little_end), .narrow_mode(narrow_mode),
    .flags_en(flags_en), .out_valid(out_valid), .mask_out(mask_out), .flag_we(flag_we),
    .cc_narrow(cc_narrow), .cc_wide(cc_wide)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Element j of the block is in the left span when j >= start index, in the
  // right span when j <= end index; big-endian puts element j at bit w-1-j.
  function automatic logic [7:0] side(input int w, input int k, input bit le, input bit lft);
    logic [7:0] m = '0;
    for (int j = 0; j < w; j++)
      if (lft ? (j >= k) : (j <= k)) m[le ? j : w - 1 - j] = 1'b1;
    return m;
  endfunction

  function automatic logic [3:0] codes(input logic [63:0] a, input logic [63:0] b, input int w);
    logic [63:0] am, bm, d;
    logic n, z, v, c;
    am = (w == 64) ? a : {32'h0, a[31:0]};
    bm = (w == 64) ? b : {32'h0, b[31:0]};
    d  = am - bm;
    n  = (w == 64) ? d[63] : d[31];
    z  = (w == 64) ? (d == 0) : (d[31:0] == 0);
    c  = am < bm;
    if (w == 64) v = (a[63] != b[63]) && (n != a[63]);
    else         v = (a[31] != b[31]) && (n != a[31]);
    return {n, z, v, c};
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input int sz,
                       input bit le, input bit nar, input bit fe, input string tag);
    exp_t e;
    int w, ka, kb;
    logic [7:0] l, r;
    logic [63:0] ac, bc;
    w  = (sz == 1) ? 4 : (sz == 2) ? 2 : 8;
    ka = (sz == 1) ? int'(a[2:1]) : (sz == 2) ? int'(a[2]) : int'(a[2:0]);
    kb = (sz == 1) ? int'(b[2:1]) : (sz == 2) ? int'(b[2]) : int'(b[2:0]);
    l  = side(w, ka, le, 1'b1);
    r  = side(w, kb, le, 1'b0);
    ac = nar ? {32'h0, a[31:0]} : a;
    bc = nar ? {32'h0, b[31:0]} : b;
    e.mask = {56'h0, ((ac >> 3) == (bc >> 3)) ? (l & r) : l};
    if (fe) begin
      cn_m = codes(a, b, 32);
      cw_m = codes(a, b, 64);
    end
    e.we = fe; e.cn = cn_m; e.cw = cw_m; e.tag = tag;
    @(negedge clk);
    addr_a = a; addr_b = b; elem_size = 2'(sz);
    little_end = le; narrow_mode = nar; flags_en = fe; in_valid = 1'b1;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", 64'(out_valid), 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(mask_out == e.mask, e.tag, mask_out, e.mask);
        check(flag_we == e.we, "R10 strobe", 64'(flag_we), 64'(e.we));
        check(cc_wide == e.cw, "R8 wide codes", 64'(cc_wide), 64'(e.cw));
        check(cc_narrow == e.cn, "R9 narrow codes", 64'(cc_narrow), 64'(e.cn));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && mask_out == 0 && flag_we == 0 && cc_wide == 0 && cc_narrow == 0,
          "R11 reset", {out_valid, flag_we, cc_wide, cc_narrow}, 64'h0);
    rst_n = 1'b1;

    drive(64'h10, 64'h13, 0, 0, 0, 1, "R2");
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R1 latency", 64'(out_valid), 64'h1);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 single pulse", 64'(out_valid), 64'h0);

    for (int sz = 0; sz < 4; sz++)
      for (int le = 0; le < 2; le++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            drive(64'h1000 + 64'(i), 64'h1000 + 64'(j), sz, le[0], 0, (i + j) % 3 == 0,
                  sz == 3 ? "R12" : sz == 2 ? "R5" : sz == 1 ? "R4" : le ? "R3" : "R2");

    for (int sz = 0; sz < 3; sz++)
      for (int i = 0; i < 8; i++)
        drive(64'h2000 + 64'(i), 64'h2008 + 64'(7 - i), sz, i[0], 0, 0, "R6");

    drive(64'h1_0000_0010, 64'h2_0000_0015, 0, 0, 1, 1, "R7");
    drive(64'h1_0000_0010, 64'h2_0000_0015, 0, 0, 0, 0, "R7");
    drive(64'h0, 64'h1, 0, 1, 0, 1, "R8");
    drive(64'h8000_0000_0000_0000, 64'h1, 1, 0, 0, 1, "R8");
    drive(64'h0000_0000_8000_0000, 64'h1, 2, 1, 1, 1, "R9");
    drive(64'h5, 64'h5, 0, 0, 0, 1, "R8");
    drive(64'h7, 64'h3, 0, 0, 0, 0, "R10");
    for (int t = 0; t < 40; t++)
      drive({$urandom, $urandom}, {$urandom, $urandom}, t % 4, t[0], t[1], t[2], "R6");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R1 drained", 64'(q.size()), 64'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule